// File: doc/BRIEF.md
# Block-Write Serial Configuration Slave

This block is a two-wire serial slave that gives a host write and read access to a bank of byte-wide configuration registers. The host addresses it with one 7-bit device address. The read/write bit picks between a block write and a block read. Neither direction carries a register address. A write always fills registers upward from index 0. A read always returns a length byte and then the registers from index 0 upward.

The clock and data lines are sampled on a fast system clock through two-flop synchronizers. Start and stop conditions are taken from data edges while the clock line is high. The data line is driven with open-drain semantics: the block only ever pulls it low. The register contents are exposed as a flat parallel bus. Each register also has a one-cycle load strobe for downstream logic.

Two register pairs are committed atomically through a shadow byte, so a half-written pair never reaches the outputs. The length register limits how many register bytes a read returns.

Top module: `cfg_serial_slave`

## Requirements
- R1: After reset, register 8 holds 0x08 and every other register holds 0x00, no load strobe is high, and SDA is not pulled low.
- R2: The address byte 0xD2 (write) or 0xD3 (read) is acknowledged by pulling SDA low during the ninth clock. Any other address byte is not acknowledged, and the rest of that transfer is ignored until the next start.
- R3: In a write, the two bytes after the address are acknowledged and discarded. Every later byte is acknowledged and stored into registers 0, 1, 2, and so on in order.
- R4: A stop after any complete byte ends the write. The next write starts again at register 0, and registers that were not reached keep their values.
- R5: Registers 11 and 12 form a pair, and registers 13 and 14 form another. Both registers of a pair load together when the second byte of the pair is acknowledged. If the transfer ends after only the first byte of a pair, neither register changes and neither strobes.
- R6: A read returns the value of register 8 first, then registers 0, 1, 2 and so on, MSB first. Each following byte is sent only after the master acknowledges the previous one.
- R7: During a read, the byte at position k ≥ 1 returns 0xFF when k−1 is not below the value of register 8, or when k−1 is not below the register count (21).
- R8: When the master answers a read byte with NACK, the slave stops driving SDA and keeps it released until the next start.
- R9: A write of 0x00 to register 8 is ignored: the register keeps its value and does not strobe. Register 8 is never 0.
- R10: Every stored byte raises that register's load strobe for one cycle, in the cycle the new value appears. A pair raises both strobes in the same cycle.
- R11: Write bytes beyond the last register (data index 21 and up) are acknowledged and discarded.
- R12: The SDA drive changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_pull_low | output | 1 | High when the block pulls SDA low |
| cfg_regs | output | NUM_REGS*8 | Register contents, register i in bits [8i+7:8i] |
| cfg_load | output | NUM_REGS | One-cycle load strobe per register |

## Verification
The assertions assume that the master keeps each SCL low phase longer than the synchronizer latency of a few system clocks. They also assume that the master issues start and stop only while the slave has released SDA. Given these assumptions, a slave that changes SDA after a synchronized falling edge never changes it while SCL is high. The bench drives the lines on a quarter-bit grid of ten system clocks. It changes SDA one quarter-bit after SCL falls, and it sends stop only after a write acknowledge or a read NACK, so every transfer stays inside those assumptions.

// File: rtl/cfgs_pkg.sv
package cfgs_pkg;
  // protocol engine phases
  typedef enum logic [2:0] {
    PS_IDLE,   // waiting for start
    PS_RX,     // shifting in address or write data
    PS_ACK,    // slave pulls SDA low for the ninth clock
    PS_TX,     // shifting out read data
    PS_MACK    // master answers ACK/NACK
  } ps_e;
endpackage

// File: rtl/cfgs_line_sync.sv
module cfgs_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_q, scl_n;
  logic [2:0] sda_q, sda_n;

  always_comb begin
    scl_n = {scl_q[1:0], scl_in};
    sda_n = {sda_q[1:0], sda_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= scl_n;
      sda_q <= sda_n;
    end
  end

  assign scl_o      = scl_q[1];
  assign sda_o      = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/cfgs_proto_fsm.sv
module cfgs_proto_fsm
  import cfgs_pkg::*;
#(
  parameter int          IDXW  = 6,
  parameter logic [6:0]  ADDR7 = 7'h69
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [7:0]      rd_data_i,
  output logic [IDXW-1:0] rd_idx_o,
  output logic            wr_en_o,
  output logic [IDXW-1:0] wr_idx_o,
  output logic [7:0]      wr_data_o,
  output logic            sda_oe_o
);
  ps_e             st_q, st_n;
  logic [3:0]      bit_q, bit_n;
  logic [7:0]      sh_q, sh_n;
  logic            rw_q, rw_n;
  logic            aph_q, aph_n;
  logic            nack_q, nack_n;
  logic [IDXW-1:0] cnt_q, cnt_n, cnt_inc;
  logic            oe_q, oe_n;

  assign cnt_inc = (cnt_q == {IDXW{1'b1}}) ? cnt_q : cnt_q + 1'b1;

  always_comb begin
    st_n    = st_q;
    bit_n   = bit_q;
    sh_n    = sh_q;
    rw_n    = rw_q;
    aph_n   = aph_q;
    nack_n  = nack_q;
    cnt_n   = cnt_q;
    wr_en_o = 1'b0;
    if (stop_i) begin
      st_n = PS_IDLE;
    end else if (start_i) begin
      st_n  = PS_RX;
      bit_n = 4'd0;
      aph_n = 1'b1;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        PS_RX: begin
          if (rise_i && bit_q != 4'd8) begin
            sh_n  = {sh_q[6:0], sda_i};
            bit_n = bit_q + 4'd1;
          end else if (fall_i && bit_q == 4'd8) begin
            if (aph_q) begin
              if (sh_q[7:1] == ADDR7) begin
                st_n = PS_ACK;
                rw_n = sh_q[0];
              end else begin
                st_n = PS_IDLE;
              end
            end else begin
              st_n    = PS_ACK;
              wr_en_o = (cnt_q >= IDXW'(2));
            end
          end
        end
        PS_ACK: begin
          if (fall_i) begin
            bit_n = 4'd0;
            aph_n = 1'b0;
            if (aph_q && rw_q) begin
              st_n = PS_TX;
              sh_n = rd_data_i;
            end else begin
              st_n = PS_RX;
              if (!aph_q) cnt_n = cnt_inc;
            end
          end
        end
        PS_TX: begin
          if (fall_i) begin
            if (bit_q == 4'd7) begin
              st_n = PS_MACK;
            end else begin
              sh_n  = {sh_q[6:0], 1'b1};
              bit_n = bit_q + 4'd1;
            end
          end
        end
        PS_MACK: begin
          if (rise_i) begin
            nack_n = sda_i;
          end else if (fall_i) begin
            if (nack_q) begin
              st_n = PS_IDLE;
            end else begin
              st_n  = PS_TX;
              sh_n  = rd_data_i;
              bit_n = 4'd0;
              cnt_n = cnt_inc;
            end
          end
        end
        default: ;
      endcase
    end
    oe_n = (st_n == PS_ACK) || (st_n == PS_TX && !sh_n[7]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_IDLE;
      bit_q  <= '0;
      sh_q   <= '0;
      rw_q   <= 1'b0;
      aph_q  <= 1'b0;
      nack_q <= 1'b0;
      cnt_q  <= '0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      rw_q   <= rw_n;
      aph_q  <= aph_n;
      nack_q <= nack_n;
      cnt_q  <= cnt_n;
      oe_q   <= oe_n;
    end
  end

  assign rd_idx_o  = (st_q == PS_MACK) ? cnt_inc : cnt_q;
  assign wr_idx_o  = cnt_q - IDXW'(2);
  assign wr_data_o = sh_q;
  assign sda_oe_o  = oe_q;

  AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_ACK && $past(st_q) != PS_ACK) |-> $past(bit_q) == 4'd8); // R3
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_i); // R12
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_MACK && fall_i && nack_q && !start_i && !stop_i) |=> !oe_q); // R8
endmodule

// File: rtl/cfgs_reg_bank.sv
module cfgs_reg_bank #(
  parameter int         NUM_REGS    = 21,
  parameter int         IDXW        = 6,
  parameter int         CNT_REG     = 8,
  parameter logic [7:0] CNT_DEFAULT = 8'h08,
  parameter int         PAIR0_LO    = 11,
  parameter int         PAIR1_LO    = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [IDXW-1:0]       wr_idx_i,
  input  logic [7:0]            wr_data_i,
  input  logic                  xfer_end_i,
  input  logic [IDXW-1:0]       rd_idx_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic [NUM_REGS-1:0]   load_o
);
  logic [NUM_REGS-1:0][7:0] regs_q, nd;
  logic [NUM_REGS-1:0]      ld, ld_q;
  logic [7:0]               sh_q, sh_n;
  logic                     shv_q, shv_n, sh_load;
  int                       w, r;

  always_comb begin
    ld      = '0;
    nd      = regs_q;
    sh_n    = sh_q;
    sh_load = 1'b0;
    shv_n   = shv_q;
    w       = int'(wr_idx_i);
    if (xfer_end_i) shv_n = 1'b0;
    if (wr_en_i && w < NUM_REGS) begin
      if (w == PAIR0_LO || w == PAIR1_LO) begin
        sh_n    = wr_data_i;
        sh_load = 1'b1;
        shv_n   = 1'b1;
      end else if (w == PAIR0_LO + 1 || w == PAIR1_LO + 1) begin
        shv_n = 1'b0;
        if (shv_q) begin
          for (int i = 0; i < NUM_REGS; i++) begin
            if (i == w)     begin ld[i] = 1'b1; nd[i] = wr_data_i; end
            if (i == w - 1) begin ld[i] = 1'b1; nd[i] = sh_q;      end
          end
        end
      end else if (!(w == CNT_REG && wr_data_i == 8'h00)) begin
        for (int i = 0; i < NUM_REGS; i++) begin
          if (i == w) begin ld[i] = 1'b1; nd[i] = wr_data_i; end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++)
        regs_q[i] <= (i == CNT_REG) ? CNT_DEFAULT : 8'h00;
      ld_q  <= '0;
      sh_q  <= '0;
      shv_q <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (ld[i]) regs_q[i] <= nd[i];
      ld_q  <= ld;
      shv_q <= shv_n;
      if (sh_load) sh_q <= sh_n;
    end
  end

  always_comb begin
    r         = int'(rd_idx_i) - 1;
    rd_data_o = 8'hFF;
    if (rd_idx_i == '0) begin
      rd_data_o = regs_q[CNT_REG];
    end else begin
      for (int i = 0; i < NUM_REGS; i++)
        if (i == r && i < int'(regs_q[CNT_REG])) rd_data_o = regs_q[i];
    end
  end

  assign regs_o = regs_q;
  assign load_o = ld_q;

  AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    regs_q[CNT_REG] != 8'h00); // R9
  AST_PAIR_SHADOWED: assert property (@(posedge clk) disable iff (!rst_n)
    (ld[PAIR0_LO + 1] || ld[PAIR1_LO + 1]) |-> $past(shv_q)); // R5
  AST_LOAD_AT_MOST_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ld_q) <= 2); // R10
endmodule

// File: rtl/cfg_serial_slave.sv
module cfg_serial_slave #(
  parameter int         NUM_REGS    = 21,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         CNT_REG     = 8,
  parameter logic [7:0] CNT_DEFAULT = 8'h08,
  parameter int         PAIR0_LO    = 11,
  parameter int         PAIR1_LO    = 13
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_in,
  input  logic                  sda_in,
  output logic                  sda_pull_low,
  output logic [NUM_REGS*8-1:0] cfg_regs,
  output logic [NUM_REGS-1:0]   cfg_load
);
  localparam int IDXW = $clog2(NUM_REGS + 3) + 1;

  logic [1:0]      rst_pipe;
  logic            rst_s_n;
  logic            scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic            wr_en;
  logic [IDXW-1:0] wr_idx, rd_idx;
  logic [7:0]      wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  cfgs_line_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .scl_in     (scl_in),
    .sda_in     (sda_in),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop)
  );

  cfgs_proto_fsm #(.IDXW(IDXW), .ADDR7(DEV_ADDR)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .rise_i    (scl_rise),
    .fall_i    (scl_fall),
    .start_i   (bus_start),
    .stop_i    (bus_stop),
    .rd_data_i (rd_data),
    .rd_idx_o  (rd_idx),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .sda_oe_o  (sda_pull_low)
  );

  cfgs_reg_bank #(
    .NUM_REGS(NUM_REGS), .IDXW(IDXW), .CNT_REG(CNT_REG),
    .CNT_DEFAULT(CNT_DEFAULT), .PAIR0_LO(PAIR0_LO), .PAIR1_LO(PAIR1_LO)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .wr_en_i    (wr_en),
    .wr_idx_i   (wr_idx),
    .wr_data_i  (wr_data),
    .xfer_end_i (bus_start | bus_stop),
    .rd_idx_i   (rd_idx),
    .rd_data_o  (rd_data),
    .regs_o     (cfg_regs),
    .load_o     (cfg_load)
  );
endmodule

// File: tb/sim_cfg_serial_slave.sv
module sim_cfg_serial_slave;
  localparam int N = 21;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_pull_low;
  logic [N*8-1:0] cfg_regs;
  logic [N-1:0]   cfg_load;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull_low;

  cfg_serial_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull_low(sda_pull_low), .cfg_regs(cfg_regs), .cfg_load(cfg_load)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mdl [N];
  int exp_ld [N];
  int ld_seen [N];
  bit settled = 0;
  int mon_bad = 0;
  int r12_bad = 0;
  logic drv_prev = 1'b0;

  function automatic logic [N*8-1:0] mdl_flat();
    logic [N*8-1:0] f;
    for (int i = 0; i < N; i++) f[i*8 +: 8] = mdl[i];
    return f;
  endfunction

  // per-clock comparison against the reference model
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_pull_low !== drv_prev && scl_m) r12_bad++;
      drv_prev = sda_pull_low;
      for (int i = 0; i < N; i++) ld_seen[i] += int'(cfg_load[i]);
      if (settled && cfg_regs !== mdl_flat()) mon_bad++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic qw(input int n = Q);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; qw();
    sda_m = 1'b0; qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw();
    scl_m = 1'b1; qw();
    sda_m = 1'b1; qw(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qw();
      scl_m = 1'b1; qw(2*Q);
      scl_m = 1'b0; qw();
    end
    sda_m = 1'b1; qw();
    scl_m = 1'b1; qw();
    acked = (sda_line == 1'b0);
    qw();
    scl_m = 1'b0; qw();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw();
      scl_m = 1'b1; qw();
      b[i] = sda_line;
      qw();
      scl_m = 1'b0; qw();
    end
    sda_m = ~give_ack; qw();
    scl_m = 1'b1; qw(2*Q);
    scl_m = 1'b0; qw();
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] exp_rd(input int k);
    if (k == 0) return mdl[8];
    if ((k - 1) < int'(mdl[8]) && (k - 1) < N) return mdl[k - 1];
    return 8'hFF;
  endfunction

  task automatic compare_state(input string req);
    int bad;
    bad = 0;
    for (int i = 0; i < N; i++) if (cfg_regs[i*8 +: 8] !== mdl[i]) bad++;
    chk(bad == 0, req, "registers differing from model", bad, 0);
    bad = 0;
    for (int i = 0; i < N; i++) if (ld_seen[i] != exp_ld[i]) bad++;
    chk(bad == 0, "R10", "registers with wrong strobe count", bad, 0);
  endtask

  task automatic wr_xfer(input logic [7:0] dq[$], input string req);
    bit a;
    int k;
    settled = 0;
    bus_start();
    send_byte(8'hD2, a); chk(a, "R2", "write address ack", a, 1);
    send_byte(8'h5A, a); chk(a, "R3", "command byte ack", a, 1);
    send_byte(8'h77, a); chk(a, "R3", "count byte ack", a, 1);
    for (int j = 0; j < dq.size(); j++) begin
      send_byte(dq[j], a);
      chk(a, (j >= N) ? "R11" : "R3", "data byte ack", a, 1);
    end
    bus_stop();
    k = 0;
    while (k < dq.size()) begin
      if (k >= N) begin
        k++;
      end else if (k == 11 || k == 13) begin
        if (k + 1 < dq.size()) begin
          mdl[k] = dq[k]; mdl[k+1] = dq[k+1];
          exp_ld[k]++; exp_ld[k+1]++;
        end
        k += 2;
      end else if (k == 8 && dq[k] == 8'h00) begin
        k++;
      end else begin
        mdl[k] = dq[k]; exp_ld[k]++;
        k++;
      end
    end
    qw(4);
    settled = 1;
    compare_state(req);
  endtask

  task automatic rd_xfer(input int n, input string req);
    bit a;
    logic [7:0] b;
    bit low_seen;
    bus_start();
    send_byte(8'hD3, a); chk(a, "R2", "read address ack", a, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(b === exp_rd(k), (k == 0) ? "R6" : (exp_rd(k) == 8'hFF ? "R7" : req),
          "read byte", b, exp_rd(k));
    end
    // R8: after NACK the slave must leave SDA released
    low_seen = 0;
    for (int p = 0; p < 9; p++) begin
      qw(); scl_m = 1'b1; qw();
      if (sda_line == 1'b0) low_seen = 1;
      qw(); scl_m = 1'b0; qw();
    end
    chk(!low_seen, "R8", "SDA pulled after NACK", low_seen, 0);
    bus_stop();
  endtask

  initial begin
    logic [7:0] dq[$];
    bit a;
    for (int i = 0; i < N; i++) begin
      mdl[i] = (i == 8) ? 8'h08 : 8'h00;
      exp_ld[i] = 0;
      ld_seen[i] = 0;
    end
    qw(5);
    rst_n = 1'b1;
    qw(5);
    // R1 reset state
    chk(cfg_regs === mdl_flat(), "R1", "reset register image", cfg_regs[71:64], 8'h08);
    chk(cfg_load === '0, "R1", "reset load strobes", cfg_load, 0);
    chk(sda_pull_low === 1'b0, "R1", "reset SDA drive", sda_pull_low, 0);
    settled = 1;

    // default readback: count 8, then regs 0..7, then 0xFF
    rd_xfer(11, "R6");

    // full write including bytes past the end; count becomes 12
    dq = {};
    for (int k = 0; k < N + 2; k++) dq.push_back((k == 8) ? 8'd12 : 8'h40 + 8'(k));
    wr_xfer(dq, "R3");
    rd_xfer(16, "R6");

    // early stop after three data bytes
    dq = {8'h91, 8'h92, 8'h93};
    wr_xfer(dq, "R4");

    // stop after first byte of pair at 11
    dq = {};
    for (int k = 0; k < 12; k++) dq.push_back((k == 8) ? 8'd12 : 8'hC0 + 8'(k));
    wr_xfer(dq, "R5");

    // pair 11/12 complete, stop after first byte of pair 13
    dq = {};
    for (int k = 0; k < 14; k++) dq.push_back((k == 8) ? 8'd12 : 8'h20 + 8'(k));
    wr_xfer(dq, "R5");

    // zero written to count register is ignored
    dq = {};
    for (int k = 0; k < 9; k++) dq.push_back((k == 8) ? 8'h00 : 8'h30 + 8'(k));
    wr_xfer(dq, "R9");
    chk(cfg_regs[8*8 +: 8] === 8'd12, "R9", "count register after zero write",
        cfg_regs[8*8 +: 8], 12);

    // unknown address: nothing acknowledged, nothing stored
    settled = 0;
    bus_start();
    send_byte(8'hA4, a); chk(!a, "R2", "foreign address ack", a, 0);
    send_byte(8'h00, a); chk(!a, "R2", "byte after foreign address ack", a, 0);
    send_byte(8'h66, a); chk(!a, "R2", "byte after foreign address ack", a, 0);
    bus_stop();
    qw(4);
    settled = 1;
    compare_state("R2");

    // count larger than the bank: reads stop at the last register
    dq = {};
    for (int k = 0; k < 9; k++) dq.push_back((k == 8) ? 8'd30 : 8'h50 + 8'(k));
    wr_xfer(dq, "R3");
    rd_xfer(25, "R6");

    chk(mon_bad == 0, "R3", "cycles with register image off model", mon_bad, 0);
    chk(r12_bad == 0, "R12", "SDA drive changes while SCL high", r12_bad, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule